// File: doc/BRIEF.md
# IPv4 Header Screening and Three-Way Packet Classifier

This block sits on a 64-bit packet stream whose link-layer header has already been removed, so each packet starts directly with its IPv4 header. While a packet arrives, the block holds back the first words. It captures the header fields, folds the header checksum, and decides whether the packet may be forwarded by the hardware datapath, must be handed to the control-plane processor as an exception, or must be discarded.

The decision is posted on a separate verdict channel, together with the destination address taken from the header. The data words of the packet leave unchanged only after that verdict has been accepted. A downstream lookup or queueing stage therefore always knows the fate of a packet before its first byte reaches it. Header rewriting, route lookup and generation of control messages are left to other blocks.

Top module: `ipv4_hdr_classify`

## Requirements
- R1: Every packet leaves on the output stream with the same bytes, keep bits and last marker as it entered, in order, whatever its verdict. Byte 0 of a word is data[63:56] and is qualified by keep[7]. Keep bits are contiguous from bit 7 down, and only a last word may be partial.
- R2: For each packet, the verdict channel is valid before the first output data word of that packet is transferred. While verd_valid is high and verd_ready is low, verd_code and verd_dst stay unchanged.
- R3: verd_code uses three codes: 0 forward, 1 exception, 2 drop. A packet is forwarded only if all of the following hold:
  - the version nibble (byte 0 bits 7:4) is 4;
  - the header length nibble (byte 0 bits 3:0) is 5;
  - the checksum is valid;
  - the TTL (byte 8) is at least 2;
  - the total length field (bytes 2..3, big-endian) is within 64..1500.
- R4: The checksum is the ones-complement sum, with end-around carry, of all big-endian 16-bit words in the first 4×(header length) bytes. It is valid only when that sum is 0xFFFF. An invalid checksum gives drop, even when the TTL, options or length rule would also apply.
- R5: A packet with TTL 0 or 1 and a valid checksum gets exception.
- R6: A header length of 6 to 15 (options present) with a valid checksum gets exception. The checksum then includes the option bytes.
- R7: A version other than 4 gets exception, whatever the checksum, provided at least 20 bytes arrived.
- R8: An IPv4 packet with a header length below 5 is dropped.
- R9: A total length field below 64 or above 1500, with a valid checksum, no options and TTL at least 2, gets exception.
- R10: A packet that ends before 20 bytes, or before 4×(header length) bytes, is dropped.
- R11: verd_dst equals bytes 16..19 of the packet, with byte 16 as the most significant byte, whenever the packet carries at least 20 bytes.
- R12: After reset, in_ready is high and out_valid and verd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Incoming packet word, byte 0 in the top bits |
| in_keep | input | 8 | Byte qualifiers for in_data |
| in_last | input | 1 | Marks the final word of a packet |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word |
| out_data | output | 64 | Outgoing packet word |
| out_keep | output | 8 | Byte qualifiers for out_data |
| out_last | output | 1 | Marks the final outgoing word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| verd_valid | output | 1 | Verdict for the held packet present |
| verd_ready | input | 1 | Downstream accepts the verdict |
| verd_code | output | 2 | 0 forward, 1 exception, 2 drop |
| verd_dst | output | 32 | Destination address from the header |

## Verification
A corrupted checksum accumulator or a stale captured field shows up in the very next verdict, as a wrong code for a packet whose fields the bench set on purpose. Sweeps over version, header length, TTL, total length and truncation point make every rule boundary produce a distinct code. A wrong hold-buffer pointer or phase shows up within the same packet: bytes are reordered or duplicated, the last marker is lost, or a data word appears before the verdict. Backpressure on both output channels exposes verdict values that are not held while stalled.

// File: rtl/ipv4_cls_pkg.sv
package ipv4_cls_pkg;

    typedef enum logic [1:0] {
        VERD_FWD  = 2'd0,
        VERD_EXC  = 2'd1,
        VERD_DROP = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_VERDICT = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_PASS    = 2'd3
    } phase_e;

    localparam int WORD_W = 64;
    localparam int KEEP_W = WORD_W / 8;

endpackage

// File: rtl/ipv4_csum_lanes.sv
module ipv4_csum_lanes #(
    parameter int IDX_W = 4,
    parameter int BC_W  = 7
) (
    input  logic [15:0]      acc_in,
    input  logic [63:0]      word,
    input  logic [IDX_W-1:0] word_idx,
    input  logic [BC_W-1:0]  need_bytes,
    output logic [15:0]      acc_out
);
    localparam int LANES = 4;

    logic [LANES-1:0][15:0] lane_val;
    logic [18:0]            raw_sum;
    logic [16:0]            fold1;
    logic [16:0]            fold2;
    logic [BC_W-1:0]        base_off;

    assign base_off = BC_W'({word_idx, 3'b000});

    // each 16-bit lane counts only while its byte offset lies inside the header
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [BC_W-1:0] lane_off;
        assign lane_off    = base_off + BC_W'(2 * j);
        assign lane_val[j] = (lane_off < need_bytes) ? word[63-16*j -: 16] : 16'h0000;
    end

    always_comb begin
        raw_sum = {3'b000, acc_in};
        for (int j = 0; j < LANES; j++) begin
            raw_sum = raw_sum + {3'b000, lane_val[j]};
        end
        fold1   = {1'b0, raw_sum[15:0]} + {14'd0, raw_sum[18:16]};
        fold2   = {1'b0, fold1[15:0]} + {16'd0, fold1[16]};
        acc_out = fold2[15:0];
    end

endmodule

// File: rtl/ipv4_verdict_rules.sv
module ipv4_verdict_rules
    import ipv4_cls_pkg::*;
#(
    parameter int BC_W        = 7,
    parameter int MIN_PKT_LEN = 64,
    parameter int MAX_PKT_LEN = 1500
) (
    input  logic [3:0]      ver,
    input  logic [3:0]      ihl,
    input  logic [7:0]      ttl,
    input  logic [15:0]     tot_len,
    input  logic [15:0]     csum_fold,
    input  logic [BC_W-1:0] hdr_bytes,
    output verdict_e        verdict
);
    localparam logic [15:0]     LEN_LO   = 16'(MIN_PKT_LEN);
    localparam logic [15:0]     LEN_HI   = 16'(MAX_PKT_LEN);
    localparam logic [BC_W-1:0] BASE_HDR = BC_W'(20);

    logic [BC_W-1:0] ihl_bytes;
    logic            sum_ok;
    logic            len_out;

    assign ihl_bytes = BC_W'({ihl, 2'b00});
    assign sum_ok    = (csum_fold == 16'hFFFF);
    assign len_out   = (tot_len < LEN_LO) || (tot_len > LEN_HI);

    // ordered by priority: truncation, foreign version, malformed, checksum, exceptions
    always_comb begin
        if (hdr_bytes < BASE_HDR) begin
            verdict = VERD_DROP;
        end else if (ver != 4'd4) begin
            verdict = VERD_EXC;
        end else if (ihl < 4'd5) begin
            verdict = VERD_DROP;
        end else if (hdr_bytes < ihl_bytes) begin
            verdict = VERD_DROP;
        end else if (!sum_ok) begin
            verdict = VERD_DROP;
        end else if ((ihl != 4'd5) || (ttl <= 8'd1) || len_out) begin
            verdict = VERD_EXC;
        end else begin
            verdict = VERD_FWD;
        end
    end

endmodule

// File: rtl/ipv4_hold_buf.sv
module ipv4_hold_buf #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic [7:0]       wr_keep,
    input  logic             wr_last,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data,
    output logic [7:0]       rd_keep,
    output logic             rd_last
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [63:0] data;
        logic [7:0]  keep;
        logic        last;
    } slot_t;

    slot_t [DEPTH-1:0] mem_q;
    slot_t [DEPTH-1:0] mem_d;
    slot_t             rd_slot;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (wr_idx < IDX_W'(DEPTH))) begin
            mem_d[wr_idx[AW-1:0]] = '{data: wr_data, keep: wr_keep, last: wr_last};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_slot = '0;
        if (rd_idx < IDX_W'(DEPTH)) begin
            rd_slot = mem_q[rd_idx[AW-1:0]];
        end
    end

    assign rd_data = rd_slot.data;
    assign rd_keep = rd_slot.keep;
    assign rd_last = rd_slot.last;

endmodule

// File: rtl/ipv4_hdr_classify.sv
module ipv4_hdr_classify
    import ipv4_cls_pkg::*;
#(
    parameter int HDR_WORDS   = 8,
    parameter int MIN_PKT_LEN = 64,
    parameter int MAX_PKT_LEN = 1500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] in_data,
    input  logic [7:0]  in_keep,
    input  logic        in_last,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [63:0] out_data,
    output logic [7:0]  out_keep,
    output logic        out_last,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        verd_valid,
    input  logic        verd_ready,
    output logic [1:0]  verd_code,
    output logic [31:0] verd_dst
);
    localparam int IDX_W = $clog2(HDR_WORDS + 1);
    localparam int BC_W  = IDX_W + 3;

    typedef struct packed {
        phase_e          phase;
        logic [IDX_W-1:0] wcnt;
        logic [IDX_W-1:0] rptr;
        logic [BC_W-1:0]  nbytes;
        logic [3:0]       ver;
        logic [3:0]       ihl;
        logic [7:0]       ttl;
        logic [15:0]      tlen;
        logic [31:0]      dst;
        logic [15:0]      acc;
        verdict_e         verd;
        logic             tail_in_buf;
    } ctl_t;

    ctl_t q, d;

    logic [3:0]       f_ver, f_ihl;
    logic [7:0]       f_ttl;
    logic [15:0]      f_tlen;
    logic [31:0]      f_dst;
    logic [BC_W-1:0]  need_now;
    logic [BC_W-1:0]  nb_after;
    logic [3:0]       kcnt;
    logic [15:0]      acc_seed;
    logic [15:0]      acc_nx;
    verdict_e         verd_nx;
    logic             hdr_done;
    logic             buf_we;
    logic [63:0]      buf_data;
    logic [7:0]       buf_keep;
    logic             buf_last;
    logic [IDX_W-1:0] last_idx;

    // fields of the current word, or those already captured
    assign f_ver  = (q.wcnt == '0) ? in_data[63:60] : q.ver;
    assign f_ihl  = (q.wcnt == '0) ? in_data[59:56] : q.ihl;
    assign f_tlen = (q.wcnt == '0) ? in_data[47:32] : q.tlen;
    assign f_ttl  = (q.wcnt == IDX_W'(1)) ? in_data[63:56] : q.ttl;
    assign f_dst  = (q.wcnt == IDX_W'(2)) ? in_data[63:32] : q.dst;

    assign need_now = (f_ihl < 4'd5) ? BC_W'(20) : BC_W'({f_ihl, 2'b00});
    assign kcnt     = 4'($countones(in_keep));
    assign nb_after = q.nbytes + BC_W'(kcnt);
    assign hdr_done = (nb_after >= need_now);
    assign acc_seed = (q.wcnt == '0) ? 16'h0000 : q.acc;
    assign last_idx = q.wcnt - IDX_W'(1);

    ipv4_csum_lanes #(
        .IDX_W(IDX_W),
        .BC_W (BC_W)
    ) u_csum (
        .acc_in    (acc_seed),
        .word      (in_data),
        .word_idx  (q.wcnt),
        .need_bytes(need_now),
        .acc_out   (acc_nx)
    );

    ipv4_verdict_rules #(
        .BC_W       (BC_W),
        .MIN_PKT_LEN(MIN_PKT_LEN),
        .MAX_PKT_LEN(MAX_PKT_LEN)
    ) u_rules (
        .ver      (f_ver),
        .ihl      (f_ihl),
        .ttl      (f_ttl),
        .tot_len  (f_tlen),
        .csum_fold(acc_nx),
        .hdr_bytes(nb_after),
        .verdict  (verd_nx)
    );

    ipv4_hold_buf #(
        .DEPTH(HDR_WORDS),
        .IDX_W(IDX_W)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (buf_we),
        .wr_idx (q.wcnt),
        .wr_data(in_data),
        .wr_keep(in_keep),
        .wr_last(in_last),
        .rd_idx (q.rptr),
        .rd_data(buf_data),
        .rd_keep(buf_keep),
        .rd_last(buf_last)
    );

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = buf_data;
        out_keep  = buf_keep;
        out_last  = buf_last;
        buf_we    = 1'b0;
        unique case (q.phase)
            ST_COLLECT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    buf_we   = 1'b1;
                    d.wcnt   = q.wcnt + IDX_W'(1);
                    d.nbytes = nb_after;
                    d.ver    = f_ver;
                    d.ihl    = f_ihl;
                    d.tlen   = f_tlen;
                    d.ttl    = f_ttl;
                    d.dst    = f_dst;
                    d.acc    = acc_nx;
                    if (in_last || hdr_done) begin
                        d.phase       = ST_VERDICT;
                        d.verd        = verd_nx;
                        d.tail_in_buf = in_last;
                    end
                end
            end
            ST_VERDICT: begin
                if (verd_ready) begin
                    d.phase = ST_DRAIN;
                    d.rptr  = '0;
                end
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    if (q.rptr == last_idx) begin
                        if (q.tail_in_buf) begin
                            d.phase  = ST_COLLECT;
                            d.wcnt   = '0;
                            d.nbytes = '0;
                            d.rptr   = '0;
                            d.dst    = '0;
                        end else begin
                            d.phase = ST_PASS;
                        end
                    end else begin
                        d.rptr = q.rptr + IDX_W'(1);
                    end
                end
            end
            ST_PASS: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = in_data;
                out_keep  = in_keep;
                out_last  = in_last;
                if (in_valid && out_ready && in_last) begin
                    d.phase  = ST_COLLECT;
                    d.wcnt   = '0;
                    d.nbytes = '0;
                    d.rptr   = '0;
                    d.dst    = '0;
                end
            end
            default: d.phase = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= ST_COLLECT;
            q.verd  <= VERD_DROP;
        end else begin
            q <= d;
        end
    end

    assign verd_valid = (q.phase == ST_VERDICT);
    assign verd_code  = q.verd;
    assign verd_dst   = q.dst;

    AST_BUF_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_COLLECT && in_valid) |-> (q.wcnt < IDX_W'(HDR_WORDS))); // R1

    AST_VERD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (verd_valid && !verd_ready) |=> (verd_valid && $stable(verd_code) && $stable(verd_dst))); // R2

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        verd_valid |-> (verd_code != 2'd3)); // R3

    AST_FWD_SUM_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (verd_valid && verd_code == VERD_FWD) |-> (q.acc == 16'hFFFF)); // R4

    AST_FWD_TTL: assert property (@(posedge clk) disable iff (!rst_n)
        (verd_valid && verd_code == VERD_FWD) |-> (q.ttl > 8'd1)); // R5

    AST_FWD_NO_OPT: assert property (@(posedge clk) disable iff (!rst_n)
        (verd_valid && verd_code == VERD_FWD) |-> (q.ihl == 4'd5)); // R6

    AST_DATA_AFTER_VERD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (q.phase != ST_COLLECT)); // R2

endmodule

// File: tb/tb_ipv4_hdr_classify.sv
module tb_ipv4_hdr_classify;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] in_data;
    logic [7:0]  in_keep;
    logic        in_last, in_valid, in_ready;
    logic [63:0] out_data;
    logic [7:0]  out_keep;
    logic        out_last, out_valid, out_ready;
    logic        verd_valid, verd_ready;
    logic [1:0]  verd_code;
    logic [31:0] verd_dst;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic bp_on = 1'b0;

    logic [7:0] pkt [0:127];
    int         plen;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ipv4_hdr_classify dut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_keep(in_keep), .in_last(in_last),
        .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .verd_valid(verd_valid), .verd_ready(verd_ready),
        .verd_code(verd_code), .verd_dst(verd_dst)
    );

    function automatic logic [15:0] hdr_sum(input int nbytes);
        logic [31:0] s = 0;
        for (int i = 0; i + 1 < nbytes; i += 2) s += {pkt[i], pkt[i+1]};
        while (s[31:16] != 0) s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
        return s[15:0];
    endfunction

    // expected verdict from the requirements: 0 fwd, 1 exc, 2 drop
    function automatic logic [1:0] exp_code(output string tag);
        int ver = pkt[0][7:4];
        int ihl = pkt[0][3:0];
        int tl  = {pkt[2], pkt[3]};
        if (plen < 20)              begin tag = "R10"; return 2'd2; end
        if (ver != 4)               begin tag = "R7";  return 2'd1; end
        if (ihl < 5)                begin tag = "R8";  return 2'd2; end
        if (plen < ihl * 4)         begin tag = "R10"; return 2'd2; end
        if (hdr_sum(ihl * 4) != 16'hFFFF) begin tag = "R4"; return 2'd2; end
        if (ihl > 5)                begin tag = "R6";  return 2'd1; end
        if (pkt[8] <= 1)            begin tag = "R5";  return 2'd1; end
        if (tl < 64 || tl > 1500)   begin tag = "R9";  return 2'd1; end
        tag = "R3";
        return 2'd0;
    endfunction

    task automatic build(input int ver, input int ihl, input int ttl, input int tl,
                         input int len, input bit bad);
        int hb;
        logic [15:0] cs;
        for (int i = 0; i < 128; i++) pkt[i] = 8'((i * 37 + len * 11 + ttl) & 255);
        pkt[0]  = {4'(ver), 4'(ihl)};
        pkt[2]  = 8'(tl >> 8);
        pkt[3]  = 8'(tl);
        pkt[8]  = 8'(ttl);
        pkt[9]  = 8'd17;
        pkt[10] = 8'd0;
        pkt[11] = 8'd0;
        hb = (ihl < 5) ? 20 : ihl * 4;
        cs = ~hdr_sum(hb);
        pkt[10] = cs[15:8];
        pkt[11] = cs[7:0];
        if (bad) pkt[15] = pkt[15] ^ 8'h01;
        plen = len;
    endtask

    task automatic send_pkt();
        int nw = (plen + 7) / 8;
        for (int w = 0; w < nw; w++) begin
            bit fired = 0;
            while (!fired) begin
                @(negedge clk);
                if (bp_on && (cyc % 5 == 2)) begin
                    in_valid = 1'b0;
                end else begin
                    in_valid = 1'b1;
                    for (int b = 0; b < 8; b++) begin
                        in_data[63-8*b -: 8] = (w*8+b < plen) ? pkt[w*8+b] : 8'hEE;
                        in_keep[7-b]         = (w*8+b < plen);
                    end
                    in_last = (w == nw - 1);
                end
                #2;
                fired = in_valid && in_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic recv_pkt(output logic [1:0] code, output logic [31:0] dst,
                            output bit order_bad, output bit data_bad);
        bit got_v = 0, done = 0, hold_pend = 0;
        logic [1:0]  h_code;
        logic [31:0] h_dst;
        int wi = 0;
        order_bad = 0; data_bad = 0; code = 2'd3; dst = 0;
        while (!done) begin
            @(negedge clk);
            verd_ready = !(bp_on && (cyc % 4 != 0));
            out_ready  = !(bp_on && (cyc % 3 == 1));
            #2;
            if (hold_pend && (!verd_valid || verd_code != h_code || verd_dst != h_dst)) order_bad = 1;
            hold_pend = verd_valid && !verd_ready;
            h_code = verd_code; h_dst = verd_dst;
            if (verd_valid && verd_ready) begin
                if (got_v) order_bad = 1;
                got_v = 1; code = verd_code; dst = verd_dst;
            end
            if (out_valid && out_ready) begin
                bit exp_last = ((wi + 1) * 8 >= plen);
                if (!got_v) order_bad = 1;
                for (int b = 0; b < 8; b++) begin
                    bit kb = (wi*8+b < plen);
                    if (out_keep[7-b] != kb) data_bad = 1;
                    if (kb && out_data[63-8*b -: 8] != pkt[wi*8+b]) data_bad = 1;
                end
                if (out_last != exp_last) data_bad = 1;
                if (out_last) done = 1;
                wi++;
            end
        end
    endtask

    task automatic run_case(input int ver, input int ihl, input int ttl, input int tl,
                            input int len, input bit bad);
        logic [1:0]  code, ec;
        logic [31:0] dst, edst;
        bit ob, db;
        string tag;
        build(ver, ihl, ttl, tl, len, bad);
        ec = exp_code(tag);
        edst = {pkt[16], pkt[17], pkt[18], pkt[19]};
        fork
            send_pkt();
            recv_pkt(code, dst, ob, db);
        join
        checks++;
        if (code != ec) begin
            errors++;
            $display("FAIL %s verdict ver=%0d ihl=%0d ttl=%0d tl=%0d len=%0d bad=%0d: actual %0d expected %0d",
                     tag, ver, ihl, ttl, tl, len, bad, code, ec);
        end
        checks++;
        if (ob) begin
            errors++;
            $display("FAIL R2 verdict ordering/hold len=%0d: actual violated expected held-before-data", len);
        end
        checks++;
        if (db) begin
            errors++;
            $display("FAIL R1 data pass-through len=%0d: actual mismatch expected identical words", len);
        end
        if (len >= 20) begin
            checks++;
            if (dst != edst) begin
                errors++;
                $display("FAIL R11 dst: actual %h expected %h", dst, edst);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual hung expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0; in_keep = '0;
        out_ready = 1'b1; verd_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        checks++;
        if (!in_ready || out_valid || verd_valid) begin
            errors++;
            $display("FAIL R12 reset: actual rdy=%0d ov=%0d vv=%0d expected 1 0 0",
                     in_ready, out_valid, verd_valid);
        end
        for (int pass = 0; pass < 2; pass++) begin
            bp_on = (pass == 1);
            // R8 R6 header length sweep, good checksum
            for (int ihl = 0; ihl < 16; ihl++) run_case(4, ihl, 64, 100, ((ihl < 5) ? 20 : ihl * 4) + 13, 0);
            // R7 version sweep
            for (int v = 0; v < 16; v++) run_case(v, 5, 64, 100, 40, 0);
            // R5 TTL sweep, R4 priority over TTL
            for (int t = 0; t < 5; t++) run_case(4, 5, t, 200, 36, 0);
            for (int t = 0; t < 3; t++) run_case(4, 5, t, 200, 36, 1);
            // R9 length window edges
            for (int tl = 62; tl < 67; tl++) run_case(4, 5, 9, tl, 44, 0);
            for (int tl = 1498; tl < 1503; tl++) run_case(4, 5, 9, tl, 44, 0);
            // R10 truncation
            for (int len = 1; len < 25; len++) run_case(4, 5, 9, 100, len, 0);
            for (int len = 20; len < 30; len++) run_case(4, 7, 9, 100, len, 0);
            // R4 R6 options with bad and good checksum, R7 with bad checksum
            run_case(4, 7, 9, 100, 50, 1);
            run_case(4, 15, 9, 100, 70, 0);
            run_case(4, 15, 9, 100, 70, 1);
            run_case(6, 5, 9, 100, 40, 1);
            run_case(4, 5, 1, 100, 40, 1);
            run_case(4, 6, 0, 30, 40, 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule